// File: doc/BRIEF.md
# Binary Seconds Real-Time Clock with Masked Alarm

This peripheral keeps wall time as a single 62-bit count of seconds. A programmable divider turns the block clock into a one-second step: with divider value P, the count advances once every P+1 clock cycles. Software talks to the block over a small 32-bit register bus with separate read and write strobes. Read data is registered and appears in the cycle after the read strobe.

Software never writes the live counter. It fills two staging words, then issues an upload command that copies them into the counter in one cycle. A flag in the control register shows whether the staged value has been committed. The control register works by command: each written bit asks for one action, such as start, stop, alarm on or off, zeroing the count, upload, or setting or clearing the wakeup. Reading it returns status.

The alarm holds a 43-bit target and a 62-bit compare mask. Each time the count steps, the block compares it with the target under the mask. When they agree and the alarm is armed, it raises a wakeup interrupt. The mode register then decides what happens to the count: it keeps running, it clears to zero, or it halts.

Top module: `sec_rtc`

## Requirements
- R1: After reset the wakeup output is low. The count, the divider and the alarm target read as zero. The control register reads 0. The mask reads all ones: 0xFFFFFFFF at offset 0x14 and 0x3FFFFFFF at offset 0x18.
- R2: While running, the count rises by one every P+1 clock cycles, where P is the divider at offset 0x08. A start command (control bit 0) restarts the divider phase. A stop command (bit 1) freezes the count, and stop wins when both are written together. Control read bit 0 shows running.
- R3: Writes to the time words (0x20 low, 0x24 high) only stage a value. An upload command (control bit 5) commits it in the same edge. Control read bit 5 is 1 after an upload, 0 after any later staging write, and 0 after reset.
- R4: Only the defined bits are kept: 26 divider bits, 30 bits in the time high word, 11 bits in the alarm high word (0x10), 30 bits in the mask high word, and mode bits 1..3 at offset 0x04. All other bits read as 0.
- R5: A read of the time low word also copies the count's upper 30 bits into a shadow. A read of the time high word returns that shadow, so a low-then-high pair stays coherent even if a carry happens between the two reads.
- R6: An upload that falls on the same edge as a step loads the staged value exactly, with no added second, and it restarts the divider phase.
- R7: The alarm is armed when control read bit 2 (set by bit 2, cleared by bit 3) and mode bit 1 are both 1. When armed, the wakeup output rises one cycle after the count takes a value V with ((V xor target) and mask) = 0. The target is offsets 0x0C/0x10, zero-extended. Control read bit 7 mirrors the wakeup.
- R8: An alarm-off command (bit 3) or a wakeup-clear command (bit 8) drops the wakeup on the next edge, and alarm-off also disarms the alarm. A wakeup-set command (bit 9) raises it. Clear wins over set in the same write.
- R9: Mask bits at 0 are ignored in the match, so a target can match a whole range of counts.
- R10: On a match with mode bit 3 (continue) set, the count keeps running. With mode bit 2 (wake reset) set, the count goes to zero. Without continue, the clock halts.
- R11: A zero command (control bit 4) clears the count and the divider phase and leaves the running state as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider reference |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Wakeup interrupt, level |

## Verification
The collision that matters most is an upload landing on the same edge as a one-second step. The bench provokes it by running with a divider of zero, so that every edge is a step, and then issuing the upload. It passes only if the next read returns exactly the staged value, and the read after that returns that value plus one. A second collision is an alarm match on the same edge as a step: with wake reset set and the clock still stepping every cycle, the count must read zero and the clock must read as halted.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TGTLO = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TGTHI = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_MSKLO = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_MSKHI = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_TMLO  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_TMHI  = 6'h24;

  localparam int CB_RUN    = 0;
  localparam int CB_HALT   = 1;
  localparam int CB_ARM    = 2;
  localparam int CB_DISARM = 3;
  localparam int CB_ZERO   = 4;
  localparam int CB_COMMIT = 5;
  localparam int CB_PEND   = 7;
  localparam int CB_WCLR   = 8;
  localparam int CB_WSET   = 9;

  localparam int MB_WEN  = 1;
  localparam int MB_WRST = 2;
  localparam int MB_WCON = 3;

  typedef struct packed {
    logic go;
    logic halt;
    logic arm;
    logic disarm;
    logic zero;
    logic commit;
    logic wclr;
    logic wset;
  } ctl_cmd_t;
endpackage

// File: rtl/sec_rtc_div.sv
module sec_rtc_div #(
  parameter int DIV_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  assign tick = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (tick) phase_q <= '0;
      else      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/sec_rtc_cnt.sv
module sec_rtc_cnt #(
  parameter int CNT_W = 62
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic             clr,
  input  logic [CNT_W-1:0] stage,
  output logic [CNT_W-1:0] cnt,
  output logic             stepped
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      stepped <= 1'b0;
    end else begin
      stepped <= tick && !load && !clr;
      if (load)      cnt <= stage;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sec_rtc_alm.sv
module sec_rtc_alm #(
  parameter int CNT_W = 62,
  parameter int ALM_W = 43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             stepped,
  input  logic             armed,
  input  logic [ALM_W-1:0] target,
  input  logic [CNT_W-1:0] mask,
  input  logic             clr,
  input  logic             set,
  output logic             hit,
  output logic             pend
);
  localparam int PAD_W = CNT_W - ALM_W;

  logic [CNT_W-1:0] tgt_ext;
  assign tgt_ext = {{PAD_W{1'b0}}, target};
  assign hit     = stepped && armed && (((cnt ^ tgt_ext) & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst || clr)      pend <= 1'b0;
    else if (hit || set) pend <= 1'b1;
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int DIV_W = 26,
  parameter int CNT_W = 62,
  parameter int ALM_W = 43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int HI_W  = CNT_W - 32;
  localparam int AHI_W = ALM_W - 32;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       mode_q;
  logic [31:0]      tgt_lo_q, msk_lo_q, stg_lo_q;
  logic [AHI_W-1:0] tgt_hi_q;
  logic [HI_W-1:0]  msk_hi_q, stg_hi_q, shadow_q;
  logic             run_q, arm_q, commit_q;

  ctl_cmd_t         cmd;
  logic             ctl_wr;
  logic             tick, stepped, hit_c, pend;
  logic             load_c, clr_c, restart_c;
  logic             wake_en, wake_rst, wake_cont;
  logic [CNT_W-1:0] cnt_q, stage_w, mask_w;
  logic [ALM_W-1:0] target_w;

  assign ctl_wr = wr_en && (addr == OFS_CTRL);
  always_comb begin
    cmd        = '0;
    cmd.go     = ctl_wr && wdata[CB_RUN];
    cmd.halt   = ctl_wr && wdata[CB_HALT];
    cmd.arm    = ctl_wr && wdata[CB_ARM];
    cmd.disarm = ctl_wr && wdata[CB_DISARM];
    cmd.zero   = ctl_wr && wdata[CB_ZERO];
    cmd.commit = ctl_wr && wdata[CB_COMMIT];
    cmd.wclr   = ctl_wr && wdata[CB_WCLR];
    cmd.wset   = ctl_wr && wdata[CB_WSET];
  end

  assign wake_en   = mode_q[MB_WEN-1];
  assign wake_rst  = mode_q[MB_WRST-1];
  assign wake_cont = mode_q[MB_WCON-1];

  assign stage_w   = {stg_hi_q, stg_lo_q};
  assign mask_w    = {msk_hi_q, msk_lo_q};
  assign target_w  = {tgt_hi_q, tgt_lo_q};
  assign load_c    = cmd.commit;
  assign clr_c     = cmd.zero || (hit_c && wake_rst);
  assign restart_c = cmd.go || cmd.zero || cmd.commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      mode_q   <= '0;
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      msk_lo_q <= '1;
      msk_hi_q <= '1;
      stg_lo_q <= '0;
      stg_hi_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_MODE:  mode_q   <= wdata[MB_WCON:MB_WEN];
        OFS_DIV:   div_q    <= wdata[DIV_W-1:0];
        OFS_TGTLO: tgt_lo_q <= wdata;
        OFS_TGTHI: tgt_hi_q <= wdata[AHI_W-1:0];
        OFS_MSKLO: msk_lo_q <= wdata;
        OFS_MSKHI: msk_hi_q <= wdata[HI_W-1:0];
        OFS_TMLO:  stg_lo_q <= wdata;
        OFS_TMHI:  stg_hi_q <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      arm_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      if (hit_c && !wake_cont) run_q <= 1'b0;
      else if (cmd.halt)       run_q <= 1'b0;
      else if (cmd.go)         run_q <= 1'b1;

      if (cmd.disarm)   arm_q <= 1'b0;
      else if (cmd.arm) arm_q <= 1'b1;

      if (cmd.commit) commit_q <= 1'b1;
      else if (wr_en && (addr == OFS_TMLO || addr == OFS_TMHI)) commit_q <= 1'b0;
    end
  end

  sec_rtc_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .restart(restart_c),
    .limit(div_q), .tick(tick)
  );

  sec_rtc_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(load_c), .clr(clr_c),
    .stage(stage_w), .cnt(cnt_q), .stepped(stepped)
  );

  sec_rtc_alm #(.CNT_W(CNT_W), .ALM_W(ALM_W)) u_alm (
    .clk(clk), .rst(rst), .cnt(cnt_q), .stepped(stepped),
    .armed(arm_q && wake_en), .target(target_w), .mask(mask_w),
    .clr(cmd.disarm || cmd.wclr), .set(cmd.wset),
    .hit(hit_c), .pend(pend)
  );

  assign irq = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      shadow_q <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      case (addr)
        OFS_CTRL: begin
          rdata[CB_RUN]    <= run_q;
          rdata[CB_ARM]    <= arm_q;
          rdata[CB_COMMIT] <= commit_q;
          rdata[CB_PEND]   <= pend;
        end
        OFS_MODE:  rdata[MB_WCON:MB_WEN] <= mode_q;
        OFS_DIV:   rdata[DIV_W-1:0] <= div_q;
        OFS_TGTLO: rdata <= tgt_lo_q;
        OFS_TGTHI: rdata[AHI_W-1:0] <= tgt_hi_q;
        OFS_MSKLO: rdata <= msk_lo_q;
        OFS_MSKHI: rdata[HI_W-1:0] <= msk_hi_q;
        OFS_TMLO: begin
          rdata    <= cnt_q[31:0];
          shadow_q <= cnt_q[CNT_W-1:32];
        end
        OFS_TMHI:  rdata[HI_W-1:0] <= shadow_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int CNT_W = 62
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [5:0]       addr,
  input logic [31:0]      wdata,
  input logic             irq,
  input logic             run,
  input logic             load,
  input logic             clr,
  input logic             hit,
  input logic             committed,
  input logic             wake_cont,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] stage
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !irq);

  assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !load && !clr && !hit) |=> $stable(cnt));

  assert_commit_flag_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> committed);

  assert_exact_load_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(stage)));

  assert_disarm_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 6'h00 && wdata[3]) |=> !irq);

  assert_halt_on_match_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && !wake_cont) |=> !run);
endmodule

bind sec_rtc sec_rtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .run(run_q), .load(load_c), .clr(clr_c), .hit(hit_c),
  .committed(commit_q), .wake_cont(wake_cont), .cnt(cnt_q), .stage(stage_w)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          mon_arm = 1'b0;

  always #10 clk = ~clk;

  sec_rtc u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk);
    #1 rd_en = 1'b0;
    mon_arm = 1'b1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
    end
  endtask

  always @(negedge clk) begin
    if (mon_arm) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
      end
      mon_arm = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    chk_irq(1'b0, "R1 irq");
    rd(6'h00, 32'h0, "R1 ctrl");
    rd(6'h08, 32'h0, "R1 divider");
    rd(6'h14, 32'hFFFF_FFFF, "R1 mask lo");
    rd(6'h18, 32'h3FFF_FFFF, "R1 mask hi");
    rd(6'h20, 32'h0, "R1 time lo");

    // R4 width limits
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, 32'h03FF_FFFF, "R4 divider");
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, 32'h0000_000E, "R4 mode");
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, 32'h0000_07FF, "R4 target hi");
    wr(6'h04, 32'h0); wr(6'h10, 32'h0);

    // R3 staged upload
    wr(6'h08, 32'd3);
    wr(6'h20, 32'hFFFF_FFF0);
    wr(6'h24, 32'hC000_0005);
    rd(6'h00, 32'h0, "R3 not committed");
    wr(6'h00, 32'h20);
    rd(6'h00, 32'h20, "R3 committed flag");
    rd(6'h20, 32'hFFFF_FFF0, "R3 time lo");
    rd(6'h24, 32'h0000_0005, "R4 time hi masked");

    // R2 period P+1 = 4
    wr(6'h00, 32'h1);
    repeat (20) @(posedge clk);
    rd(6'h20, 32'hFFFF_FFF5, "R2 five steps");
    wr(6'h00, 32'h2);
    repeat (30) @(posedge clk);
    rd(6'h20, 32'hFFFF_FFF5, "R2 frozen");

    // R5 coherent pair across a carry, divider 0
    wr(6'h08, 32'd0);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h00, 32'h0, "R3 flag cleared by staging");
    wr(6'h24, 32'h12);
    wr(6'h00, 32'h20);
    wr(6'h00, 32'h1);
    rd(6'h20, 32'hFFFF_FFFF, "R5 lo before carry");
    rd(6'h24, 32'h12, "R5 shadow hi");
    rd(6'h20, 32'h1, "R5 lo after carry");
    rd(6'h24, 32'h13, "R5 shadow hi after carry");

    // R6 upload on a step edge
    wr(6'h20, 32'h100);
    wr(6'h24, 32'h0);
    wr(6'h00, 32'h21);
    rd(6'h20, 32'h100, "R6 exact staged value");
    rd(6'h20, 32'h101, "R6 next step");

    // R11 zero command keeps running
    wr(6'h00, 32'h10);
    rd(6'h20, 32'h0, "R11 zeroed");
    rd(6'h20, 32'h1, "R11 still running");
    rd(6'h00, 32'h21, "R11 ctrl running");

    // R2 stop beats start
    wr(6'h00, 32'h3);
    rd(6'h00, 32'h20, "R2 stop wins");

    // R7 exact match, continue mode
    wr(6'h04, 32'hA);
    wr(6'h0C, 32'h205);
    wr(6'h20, 32'h200);
    wr(6'h00, 32'h25);
    repeat (5) @(posedge clk);
    chk_irq(1'b0, "R7 not before match");
    chk_irq(1'b1, "R7 raised after match");
    rd(6'h00, 32'hA5, "R10 continue keeps running");

    // R8 clearing paths
    wr(6'h00, 32'h9);
    chk_irq(1'b0, "R8 disarm clears");
    rd(6'h00, 32'h21, "R8 disarmed");
    wr(6'h00, 32'h200);
    chk_irq(1'b1, "R8 wakeup set");
    wr(6'h00, 32'h100);
    chk_irq(1'b0, "R8 wakeup clear");
    wr(6'h00, 32'h200);
    wr(6'h00, 32'h300);
    chk_irq(1'b0, "R8 clear beats set");
    wr(6'h00, 32'h2);

    // R9 masked match with R10 wake reset and halt
    wr(6'h14, 32'hFFFF_FFF0);
    wr(6'h0C, 32'h30);
    wr(6'h04, 32'h6);
    wr(6'h20, 32'h2C);
    wr(6'h00, 32'h25);
    repeat (4) @(posedge clk);
    chk_irq(1'b0, "R9 no match below range");
    chk_irq(1'b1, "R9 masked match");
    rd(6'h00, 32'hA4, "R10 halted after match");
    rd(6'h20, 32'h0, "R10 cleared on match");
    repeat (5) @(posedge clk);
    rd(6'h20, 32'h0, "R10 stays halted");

    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule